// File: doc/BRIEF.md
# PCI-to-ISA Interrupt Router

This block collects level-sensitive interrupt requests from seven live sources and drives them onto sixteen ISA interrupt request lines. The sources are four external PCI interrupt pins, two USB host controllers and one audio controller. Each source is steered by a programmable routing number. Each ISA line is the OR of every source whose request is recorded on that line. Routing numbers are written through a byte-wide configuration write port.

Internally every source has its own bit position. The external pins use positions 8 to 11, USB controller 0 uses 2, USB controller 1 uses 3 and audio uses 5. The other positions below 8 are tied inactive. A raw-level register holds the last sampled level of every source. Each line keeps a bitmask of the sources recorded on it.

A source's bit is written into the mask of its routed line only when that source's level changes. After every update, every line mask is ANDed with the new raw-level vector. As a result, a source that was rerouted while high loses its old line as soon as it drops, and never leaves a stale request. When a source changes level while its routing is invalid, the block pulses an error flag and leaves every line unchanged.

Top module: `pci_isa_irq_router`

## Requirements
- R1: After reset, every ISA line is low, the error flag is low and every routing is disabled. A source that rises before any write drives no line and raises no error.
- R2: The routing fields sit at fixed configuration addresses:
  - Pin 0 uses bits [7:4] of address 0x55.
  - Pin 1 uses bits [7:4] of address 0x56, and pin 2 uses bits [3:0] of address 0x56.
  - Pin 3 uses bits [7:4] of address 0x57.
  - USB controller 0, USB controller 1 and audio each use a full byte, at addresses 0x60, 0x61 and 0x62.
  - A write takes effect on the clock edge where `cfg_we` is high.
- R3: A write to any other address, or to bits [3:0] of 0x55 or 0x57, changes no routing.
- R4: A routing number of 0, or of 0xFF, disables the source. It then drives no line and raises no error.
- R5: A routing number of 2 is invalid. So is a number above 14 for the USB and audio sources, or above 15 for any other source. A level change on a source with an invalid routing raises `route_err` for exactly the one following cycle and changes no line.
- R6: Each ISA line is high while any source recorded on it is still high. The line falls only after the last of those sources drops.
- R7: A source's request is recorded only on the edge where its level differs from the previously sampled level, using the routing in force before that edge. The line output follows one cycle later. Changing the routing while the level is steady does not move the request.
- R8: When a source drops, its request is cleared from every line, including a line named by an earlier routing.
- R9: ISA lines 0 and 2 are never driven high.
- R10: If every source is low in a cycle, every ISA line is low in the next cycle.
- R11: Line 15 can be raised only by an external pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| pci_pin_lvl | input | 4 | External PCI interrupt pin levels, bit n is pin n |
| usb_lvl | input | 2 | USB controller 0 and 1 interrupt levels |
| audio_lvl | input | 1 | Audio controller interrupt level |
| isa_irq | output | 16 | ISA interrupt request lines |
| route_err | output | 1 | One-cycle pulse on a level change with an invalid routing |

## Verification
The embedded assertions check on every cycle that:
- lines 0 and 2 stay quiet;
- all lines fall one cycle after every source is low;
- line 15 rises only after an external pin was high;
- every error pulse follows a sampled level change.

The bench scenarios are what show the rest. They cover the exact field positions and ignored addresses, the OR of two sources sharing a line, and a request staying on its old line after a reroute while high until it drops. They also cover the single-cycle width of the error pulse. A random phase with frequent reroutes then compares every output against an event-driven model.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
    localparam int NUM_SRC   = 12;
    localparam int NUM_LINES = 16;
    localparam int NUM_PINS  = 4;
    localparam int NUM_FUNCS = 3;
    localparam int LINE_W    = $clog2(NUM_LINES);
    localparam int PIN_BASE  = 8;

    localparam int SRC_USB0  = 2;
    localparam int SRC_USB1  = 3;
    localparam int SRC_AUDIO = 5;

    localparam logic [7:0] ADDR_PIN0  = 8'h55;
    localparam logic [7:0] ADDR_PIN12 = 8'h56;
    localparam logic [7:0] ADDR_PIN3  = 8'h57;
    localparam logic [7:0] ADDR_USB0  = 8'h60;
    localparam logic [7:0] ADDR_USB1  = 8'h61;
    localparam logic [7:0] ADDR_AUDIO = 8'h62;

    localparam logic [7:0] ROUTE_OFF  = 8'hFF;
    localparam logic [7:0] ROUTE_RSVD = 8'd2;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    function automatic logic [7:0] max_line(input int id);
        return (id == SRC_USB0 || id == SRC_USB1 || id == SRC_AUDIO) ? 8'd14 : 8'd15;
    endfunction
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_rt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [7:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] route [NUM_SRC]
);
    logic [3:0] pin_nib  [NUM_PINS];
    logic [7:0] func_reg [NUM_FUNCS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NUM_PINS; p++)  pin_nib[p]  <= 4'h0;
            for (int f = 0; f < NUM_FUNCS; f++) func_reg[f] <= ROUTE_OFF;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                ADDR_PIN0:  pin_nib[0] <= cfg_wdata[7:4];
                ADDR_PIN12: begin
                    pin_nib[1] <= cfg_wdata[7:4];
                    pin_nib[2] <= cfg_wdata[3:0];
                end
                ADDR_PIN3:  pin_nib[3]  <= cfg_wdata[7:4];
                ADDR_USB0:  func_reg[0] <= cfg_wdata;
                ADDR_USB1:  func_reg[1] <= cfg_wdata;
                ADDR_AUDIO: func_reg[2] <= cfg_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) route[s] = 8'h00;
        route[SRC_USB0]  = func_reg[0];
        route[SRC_USB1]  = func_reg[1];
        route[SRC_AUDIO] = func_reg[2];
        for (int p = 0; p < NUM_PINS; p++) route[PIN_BASE + p] = {4'h0, pin_nib[p]};
    end
endmodule

// File: rtl/irq_src_steer.sv
module irq_src_steer
    import irq_rt_pkg::*;
#(
    parameter int SRC_ID = 0
) (
    input  logic [7:0]        route,
    output logic              ok,
    output logic              bad,
    output logic [LINE_W-1:0] line
);
    localparam logic [7:0] LIMIT = max_line(SRC_ID);

    logic off;

    always_comb begin
        off  = (route == 8'h00) || (route == ROUTE_OFF);
        bad  = !off && ((route == ROUTE_RSVD) || (route > LIMIT));
        ok   = !off && !bad;
        line = route[LINE_W-1:0];
    end
endmodule

// File: rtl/pci_isa_irq_router.sv
module pci_isa_irq_router
    import irq_rt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [7:0]           cfg_addr,
    input  logic [7:0]           cfg_wdata,
    input  logic [NUM_PINS-1:0]  pci_pin_lvl,
    input  logic [1:0]           usb_lvl,
    input  logic                 audio_lvl,
    output logic [NUM_LINES-1:0] isa_irq,
    output logic                 route_err
);
    logic [7:0]        route    [NUM_SRC];
    logic              src_ok   [NUM_SRC];
    logic              src_bad  [NUM_SRC];
    logic [LINE_W-1:0] src_line [NUM_SRC];

    src_vec_t src_lvl, raw_lvl, changed, bad_vec;
    src_vec_t line_mask [NUM_LINES];
    src_vec_t mask_nxt  [NUM_LINES];

    irq_route_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .route     (route)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_steer
            irq_src_steer #(.SRC_ID(g)) u_steer (
                .route (route[g]),
                .ok    (src_ok[g]),
                .bad   (src_bad[g]),
                .line  (src_line[g])
            );
            assign bad_vec[g] = src_bad[g];
        end
        for (g = 0; g < NUM_LINES; g++) begin : g_out
            assign isa_irq[g] = |line_mask[g];
        end
    endgenerate

    always_comb begin
        src_lvl = '0;
        src_lvl[SRC_USB0]  = usb_lvl[0];
        src_lvl[SRC_USB1]  = usb_lvl[1];
        src_lvl[SRC_AUDIO] = audio_lvl;
        src_lvl[PIN_BASE +: NUM_PINS] = pci_pin_lvl;
    end

    assign changed = src_lvl ^ raw_lvl;

    always_comb begin
        for (int l = 0; l < NUM_LINES; l++) mask_nxt[l] = line_mask[l];
        for (int s = 0; s < NUM_SRC; s++) begin
            if (changed[s] && src_ok[s]) mask_nxt[src_line[s]][s] = src_lvl[s];
        end
        for (int l = 0; l < NUM_LINES; l++) mask_nxt[l] = mask_nxt[l] & src_lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_lvl   <= '0;
            route_err <= 1'b0;
            for (int l = 0; l < NUM_LINES; l++) line_mask[l] <= '0;
        end else begin
            raw_lvl   <= src_lvl;
            route_err <= |(changed & bad_vec);
            for (int l = 0; l < NUM_LINES; l++) line_mask[l] <= mask_nxt[l];
        end
    end

    // R9: the disabled and reserved lines never rise
    a_r9_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
        !isa_irq[0] && !isa_irq[2]);

    // R10: all sources low clears every line one cycle later
    a_r10_all_low: assert property (@(posedge clk) disable iff (rst)
        (src_lvl == '0) |=> (isa_irq == '0));

    // R11: only the external pins may reach line 15
    a_r11_line15_pins: assert property (@(posedge clk) disable iff (rst)
        $rose(isa_irq[15]) |-> $past(|pci_pin_lvl));

    // R5: an error pulse always follows a sampled level change
    a_r5_err_on_event: assert property (@(posedge clk) disable iff (rst)
        route_err |-> $past(src_lvl != raw_lvl));
endmodule

// File: tb/pci_isa_irq_router_tb.sv
module pci_isa_irq_router_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [3:0]  pci_pin_lvl = 4'h0;
    logic [1:0]  usb_lvl = 2'b00;
    logic        audio_lvl = 1'b0;
    logic [15:0] isa_irq;
    logic        route_err;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int         rt [12];
    logic [11:0] rawm;
    logic [11:0] mm [16];

    always #4 clk = ~clk;

    pci_isa_irq_router u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pci_pin_lvl(pci_pin_lvl), .usb_lvl(usb_lvl),
        .audio_lvl(audio_lvl), .isa_irq(isa_irq), .route_err(route_err)
    );

    function automatic int mxl(input int id);
        return (id == 2 || id == 3 || id == 5) ? 14 : 15;
    endfunction

    function automatic logic [15:0] exp_lines();
        logic [15:0] v;
        for (int l = 0; l < 16; l++) v[l] = |mm[l];
        return v;
    endfunction

    task automatic check(input string tag, input logic [15:0] eirq, input logic eerr);
        checks++;
        if (isa_irq !== eirq || route_err !== eerr) begin
            errors++;
            $display("FAIL %s: isa_irq=%h route_err=%b expected isa_irq=%h route_err=%b",
                     tag, isa_irq, route_err, eirq, eerr);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 12; s++) rt[s] = 0;
        rt[2] = 255; rt[3] = 255; rt[5] = 255;
        rawm = '0;
        for (int l = 0; l < 16; l++) mm[l] = '0;
    endtask

    task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d,
                        input logic [3:0] p, input logic [1:0] u, input logic au,
                        input string tag);
        logic [11:0] lvl;
        logic err;
        int r;
        @(negedge clk);
        cfg_we = we; cfg_addr = a; cfg_wdata = d;
        pci_pin_lvl = p; usb_lvl = u; audio_lvl = au;
        lvl = '0;
        lvl[2] = u[0]; lvl[3] = u[1]; lvl[5] = au; lvl[11:8] = p;
        err = 1'b0;
        for (int s = 0; s < 12; s++) begin
            if (lvl[s] != rawm[s]) begin
                r = rt[s];
                if (r == 0 || r == 255) ;
                else if (r == 2 || r > mxl(s)) err = 1'b1;
                else mm[r][s] = lvl[s];
            end
        end
        for (int l = 0; l < 16; l++) mm[l] &= lvl;
        rawm = lvl;
        if (we) begin
            case (a)
                8'h55: rt[8] = int'(d[7:4]);
                8'h56: begin rt[9] = int'(d[7:4]); rt[10] = int'(d[3:0]); end
                8'h57: rt[11] = int'(d[7:4]);
                8'h60: rt[2] = int'(d);
                8'h61: rt[3] = int'(d);
                8'h62: rt[5] = int'(d);
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        check(tag, exp_lines(), err);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [3:0] p;
        logic [1:0] u;
        logic       au;
        logic [7:0] a, d;
        logic       we;
        int unused_seed;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", 16'h0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1 after reset", 16'h0, 1'b0);

        // directed corner cases
        step(0, 8'h00, 8'h00, 4'b0001, 2'b00, 0, "R1 pin0 rises with disabled routing");
        step(1, 8'h55, 8'h53, 4'b0000, 2'b00, 0, "R2 write pin0 field");
        step(0, 8'h00, 8'h00, 4'b0001, 2'b00, 0, "R2 pin0 onto line 5");
        step(1, 8'h54, 8'h70, 4'b0001, 2'b00, 0, "R3 write to unused address");
        step(1, 8'h55, 8'h70, 4'b0001, 2'b00, 0, "R7 reroute while high keeps old line");
        step(0, 8'h00, 8'h00, 4'b0001, 2'b00, 0, "R7 steady level does not move request");
        step(0, 8'h00, 8'h00, 4'b0000, 2'b00, 0, "R8 drop clears stale line");
        step(0, 8'h00, 8'h00, 4'b0001, 2'b00, 0, "R7 new routing used on next rise");
        step(1, 8'h60, 8'h07, 4'b0001, 2'b01, 0, "R4 usb0 rises while 0xFF disabled");
        step(0, 8'h00, 8'h00, 4'b0001, 2'b00, 0, "R4 usb0 falls");
        step(0, 8'h00, 8'h00, 4'b0001, 2'b01, 0, "R6 usb0 shares line 7");
        step(0, 8'h00, 8'h00, 4'b0000, 2'b01, 0, "R6 line held by remaining source");
        step(1, 8'h61, 8'h0F, 4'b0000, 2'b01, 0, "R5 usb1 routed to 15");
        step(0, 8'h00, 8'h00, 4'b0000, 2'b11, 0, "R5 usb1 above its maximum");
        step(0, 8'h00, 8'h00, 4'b0000, 2'b11, 0, "R5 error lasts one cycle");
        step(1, 8'h62, 8'h02, 4'b0000, 2'b11, 0, "R5 audio routed to 2");
        step(0, 8'h00, 8'h00, 4'b0000, 2'b11, 1, "R5 R9 audio on reserved line");
        step(1, 8'h57, 8'hF0, 4'b0000, 2'b11, 1, "R2 pin3 field");
        step(0, 8'h00, 8'h00, 4'b1000, 2'b11, 1, "R11 pin3 onto line 15");
        step(1, 8'h56, 8'h3C, 4'b1000, 2'b11, 1, "R2 pin1 and pin2 fields");
        step(0, 8'h00, 8'h00, 4'b1110, 2'b11, 1, "R2 pin1 line 3, pin2 line 12");
        step(1, 8'h60, 8'h00, 4'b1110, 2'b10, 1, "R4 usb0 drop still clears");
        step(0, 8'h00, 8'h00, 4'b1110, 2'b11, 1, "R4 usb0 routing 0 disabled");
        step(0, 8'h00, 8'h00, 4'b0000, 2'b00, 0, "R10 all sources low");

        // constrained random phase
        unused_seed = $urandom(32'd20231128);
        p = 4'b0; u = 2'b0; au = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            we = ($urandom % 4) == 0;
            case ($urandom % 8)
                0: a = 8'h55; 1: a = 8'h56; 2: a = 8'h57;
                3: a = 8'h60; 4: a = 8'h61; 5: a = 8'h62;
                6: a = 8'h3C; default: a = 8'($urandom);
            endcase
            if ($urandom % 2) d = 8'($urandom % 17);
            else d = 8'($urandom);
            if ($urandom % 16 == 0) d = 8'hFF;
            for (int b = 0; b < 4; b++) if ($urandom % 4 == 0) p[b] = ~p[b];
            for (int b = 0; b < 2; b++) if ($urandom % 4 == 0) u[b] = ~u[b];
            if ($urandom % 4 == 0) au = ~au;
            if ($urandom % 64 == 0) begin p = '0; u = '0; au = 1'b0; end
            step(we, a, d, p, u, au, "R6 R7 R8 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule